// File: doc/BRIEF.md
# Set-Associative Branch Target Predictor

This block sits beside the fetch stage of a pipelined core. In the same cycle that a fetch PC is presented, it searches a set-associative table of branch entries. Each entry holds a tag, a taken/not-taken bit and a target address. From that search it chooses the next fetch address. A hit on an entry marked taken redirects fetch to the stored target. A miss, or a hit on an entry marked not-taken, falls through to the sequential address PC + 4.

Alongside the redirect, the block registers a bundle for the decode stage. The bundle holds the fetch PC, the raw instruction word, the predicted-taken bit and the predicted next address. It travels with the instruction so that later stages can compare the guess with the real outcome.

A resolution port, driven from the memory stage, reports every resolved branch and says whether it was mispredicted. A misprediction writes the corrected direction and target into the table. If the branch is already present, its entry is updated in place. If not, a new entry is allocated with least-recently-written replacement. Two running counters record how many branches were resolved and how many were predicted correctly, so accuracy can be derived as correct/total.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, `decValid` is 0, and both counters read 0; any lookup then behaves as a miss.
- R2: A lookup that matches no valid entry in its set gives `nextPc = fetchPc + 4` and `predTaken = 0`, in the same cycle as `fetchPc`.
- R3: A lookup that hits an entry whose stored direction is taken gives `nextPc` equal to the stored target and `predTaken = 1`, in the same cycle.
- R4: A lookup that hits an entry whose stored direction is not-taken gives `nextPc = fetchPc + 4` and `predTaken = 0`.
- R5: One clock after a cycle with `fetchValid = 1`, `decValid` is 1 and `decPc`, `decInstr`, `decTaken` and `decTarget` equal that cycle's `fetchPc`, `fetchInstr`, `predTaken` and `nextPc`. One clock after a cycle with `fetchValid = 0`, `decValid` is 0.
- R6: The set index is `pc[log2(SETS)+1:2]` and the tag is all PC bits above it, where SETS = ENTRIES/WAYS (16 by default, so the index is `pc[5:2]`). Two PCs with the same index and different tags occupy separate entries.
- R7: A resolution with `resValid = 1` and `resMispredict = 1` stores `resTaken` and `resTarget` for `resPc`. A resolution with `resMispredict = 0` leaves the table unchanged.
- R8: When a mispredicted branch misses in its set, it is allocated into the lowest-numbered invalid way. If the set is full, it replaces the way whose last write is oldest.
- R9: A mispredicted branch that already has an entry overwrites that same entry, and the write counts as its most recent use for replacement.
- R10: When a lookup and a write hit the same set in one cycle, the lookup sees the contents from before the write; the write is visible from the next cycle on.
- R11: `totalCount` increases by 1 one clock after each cycle with `resValid = 1`. `correctCount` increases by 1 one clock after each such cycle that also has `resMispredict = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch is being made this cycle |
| fetchPc | input | ADDR_W | PC being fetched |
| fetchInstr | input | INSTR_W | Raw instruction word at fetchPc |
| nextPc | output | ADDR_W | Predicted next fetch address (combinational) |
| predTaken | output | 1 | Fetch is redirected to a stored target (combinational) |
| decValid | output | 1 | Decode bundle is valid |
| decPc | output | ADDR_W | PC of the bundled instruction |
| decInstr | output | INSTR_W | Raw instruction word of the bundle |
| decTaken | output | 1 | Predicted direction of the bundle |
| decTarget | output | ADDR_W | Predicted next address of the bundle |
| resValid | input | 1 | A branch resolution is reported |
| resMispredict | input | 1 | The resolved branch was mispredicted |
| resPc | input | ADDR_W | PC of the resolved branch |
| resTaken | input | 1 | Actual direction of the resolved branch |
| resTarget | input | ADDR_W | Actual target of the resolved branch |
| totalCount | output | CNT_W | Number of resolved branches |
| correctCount | output | CNT_W | Number of correctly predicted branches |

## Verification
`nextPc` and `predTaken` are combinational, so the bench drives each fetch PC just after the falling edge and samples them 1 ns later. At that point the table still holds its pre-edge contents, which is what R10 requires. The decode bundle and both counters are registered and due one rising edge after their stimulus. The bench therefore checks them at the following falling edge, against expectations saved in the previous step. Table writes are applied to the bench's own model only after that cycle's lookup has been checked, so that the model follows the same read-before-write order as the design.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Strobes from the control module to the datapath for one cycle.
  typedef struct packed {
    logic wrEn;       // write the selected way of the resolved set
    logic incTotal;   // count one resolved branch
    logic incCorrect; // count one correctly predicted branch
  } btbStrobe_t;

endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int ENTRIES = 32,
  parameter int WAYS    = 2,
  parameter int CNT_W   = 16,
  localparam int SETS   = ENTRIES / WAYS,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - 2,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic [ADDR_W-1:0]  fetchPc,
  input  logic [INSTR_W-1:0] fetchInstr,
  output logic [ADDR_W-1:0]  nextPc,
  output logic               predTaken,
  output logic               decValid,
  output logic [ADDR_W-1:0]  decPc,
  output logic [INSTR_W-1:0] decInstr,
  output logic               decTaken,
  output logic [ADDR_W-1:0]  decTarget,
  input  logic [ADDR_W-1:0]  resPc,
  input  logic               resTaken,
  input  logic [ADDR_W-1:0]  resTarget,
  input  btbStrobe_t         strobe,
  input  logic [WAY_W-1:0]   wrWay,
  output logic [WAYS-1:0]    resHitVec,
  output logic [WAYS-1:0]    resSetValid,
  output logic [CNT_W-1:0]   totalCount,
  output logic [CNT_W-1:0]   correctCount
);

  // Entry storage
  logic [WAYS-1:0]   validQ  [SETS];
  logic [WAYS-1:0]   takenQ  [SETS];
  logic [TAG_W-1:0]  tagQ    [SETS][WAYS];
  logic [ADDR_W-1:0] targetQ [SETS][WAYS];

  // Address split for both ports
  logic [IDX_W-1:0] lkIdx, resIdx;
  logic [TAG_W-1:0] lkTag, resTag;
  assign lkIdx  = fetchPc[IDX_W+1:2];
  assign lkTag  = fetchPc[ADDR_W-1:IDX_W+2];
  assign resIdx = resPc[IDX_W+1:2];
  assign resTag = resPc[ADDR_W-1:IDX_W+2];

  // Per-way tag compare on both ports
  logic [WAYS-1:0] lkHitVec;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lkHitVec[w]  = validQ[lkIdx][w]  && (tagQ[lkIdx][w]  == lkTag);
    assign resHitVec[w] = validQ[resIdx][w] && (tagQ[resIdx][w] == resTag);
  end
  assign resSetValid = validQ[resIdx];

  // Way mux for the lookup port (at most one way hits)
  logic              hitTaken;
  logic [ADDR_W-1:0] hitTarget;
  always_comb begin
    hitTaken  = 1'b0;
    hitTarget = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lkHitVec[w]) begin
        hitTaken  = hitTaken | takenQ[lkIdx][w];
        hitTarget = hitTarget | targetQ[lkIdx][w];
      end
    end
  end

  logic              redirect;
  logic [ADDR_W-1:0] seqPc;
  assign seqPc     = fetchPc + ADDR_W'(4);
  assign redirect  = (|lkHitVec) && hitTaken;
  assign nextPc    = redirect ? hitTarget : seqPc;
  assign predTaken = redirect;

  // Valid and direction bits: reset clears them
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        takenQ[s] <= '0;
      end
    end else if (strobe.wrEn) begin
      validQ[resIdx][wrWay] <= 1'b1;
      takenQ[resIdx][wrWay] <= resTaken;
    end
  end

  // Tags and targets: no reset needed, guarded by valid
  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tagQ[resIdx][wrWay]    <= resTag;
      targetQ[resIdx][wrWay] <= resTarget;
    end
  end

  // Bundle handed to decode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decPc     <= '0;
      decInstr  <= '0;
      decTaken  <= 1'b0;
      decTarget <= '0;
    end else begin
      decValid <= fetchValid;
      if (fetchValid) begin
        decPc     <= fetchPc;
        decInstr  <= fetchInstr;
        decTaken  <= redirect;
        decTarget <= nextPc;
      end
    end
  end

  // Accuracy counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      totalCount   <= '0;
      correctCount <= '0;
    end else begin
      if (strobe.incTotal)   totalCount   <= totalCount + CNT_W'(1);
      if (strobe.incCorrect) correctCount <= correctCount + CNT_W'(1);
    end
  end

  // A tag is never allocated twice in one set
  assert_hit_unique_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkHitVec));

  assert_dec_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> decValid);

  assert_dec_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> !decValid);

  assert_total_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incTotal |=> totalCount == CNT_W'($past(totalCount) + CNT_W'(1)));

  assert_correct_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    correctCount <= totalCount);

  // The decoded bundle's prediction agrees with the table at fetch time
  assert_dec_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !redirect) |=> decTarget == $past(fetchPc) + ADDR_W'(4));

endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WAYS    = 2,
  localparam int SETS   = ENTRIES / WAYS,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resValid,
  input  logic             resMispredict,
  input  logic [IDX_W-1:0] resIdx,
  input  logic [WAYS-1:0]  resHitVec,
  input  logic [WAYS-1:0]  resSetValid,
  output btbStrobe_t       strobe,
  output logic [WAY_W-1:0] wrWay
);

  // Recency rank per way: 0 = most recently written, WAYS-1 = oldest
  logic [WAY_W-1:0] ageQ [SETS][WAYS];

  logic             anyHit, anyFree;
  logic [WAY_W-1:0] hitWay, freeWay, lruWay;

  always_comb begin
    strobe.wrEn       = resValid && resMispredict;
    strobe.incTotal   = resValid;
    strobe.incCorrect = resValid && !resMispredict;

    anyHit  = |resHitVec;
    anyFree = ~&resSetValid;

    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (resHitVec[w]) hitWay = WAY_W'(w);

    freeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!resSetValid[w]) freeWay = WAY_W'(w);

    lruWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (ageQ[resIdx][w] == WAY_W'(WAYS - 1)) lruWay = WAY_W'(w);

    if (anyHit)       wrWay = hitWay;
    else if (anyFree) wrWay = freeWay;
    else              wrWay = lruWay;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ageQ[s][w] <= WAY_W'(w);
    end else if (strobe.wrEn) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == wrWay)
          ageQ[resIdx][w] <= '0;
        else if (ageQ[resIdx][w] < ageQ[resIdx][wrWay])
          ageQ[resIdx][w] <= ageQ[resIdx][w] + WAY_W'(1);
      end
    end
  end

  // A fresh allocation never displaces a valid entry while an empty way exists
  assert_victim_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !(|resHitVec) && !(&resSetValid)) |-> !resSetValid[wrWay]);

  // A branch already present is rewritten in its own way
  assert_update_inplace_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && (|resHitVec)) |-> resHitVec[wrWay]);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int ENTRIES = 32,
  parameter int WAYS    = 2,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic [ADDR_W-1:0]  fetchPc,
  input  logic [INSTR_W-1:0] fetchInstr,
  output logic [ADDR_W-1:0]  nextPc,
  output logic               predTaken,
  output logic               decValid,
  output logic [ADDR_W-1:0]  decPc,
  output logic [INSTR_W-1:0] decInstr,
  output logic               decTaken,
  output logic [ADDR_W-1:0]  decTarget,
  input  logic               resValid,
  input  logic               resMispredict,
  input  logic [ADDR_W-1:0]  resPc,
  input  logic               resTaken,
  input  logic [ADDR_W-1:0]  resTarget,
  output logic [CNT_W-1:0]   totalCount,
  output logic [CNT_W-1:0]   correctCount
);

  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  btbStrobe_t       strobe;
  logic [WAY_W-1:0] wrWay;
  logic [WAYS-1:0]  resHitVec, resSetValid;
  logic [IDX_W-1:0] resIdx;

  assign resIdx = resPc[IDX_W+1:2];

  btb_ctrl #(.ENTRIES(ENTRIES), .WAYS(WAYS)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .resValid(resValid), .resMispredict(resMispredict), .resIdx(resIdx),
    .resHitVec(resHitVec), .resSetValid(resSetValid),
    .strobe(strobe), .wrWay(wrWay)
  );

  btb_datapath #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .ENTRIES(ENTRIES),
                 .WAYS(WAYS), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .fetchInstr(fetchInstr),
    .nextPc(nextPc), .predTaken(predTaken),
    .decValid(decValid), .decPc(decPc), .decInstr(decInstr),
    .decTaken(decTaken), .decTarget(decTarget),
    .resPc(resPc), .resTaken(resTaken), .resTarget(resTarget),
    .strobe(strobe), .wrWay(wrWay),
    .resHitVec(resHitVec), .resSetValid(resSetValid),
    .totalCount(totalCount), .correctCount(correctCount)
  );

endmodule

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;

  localparam int SETS = 16;
  localparam int WAYS = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchPc = '0, fetchInstr = '0;
  logic [31:0] nextPc;
  logic        predTaken;
  logic        decValid, decTaken;
  logic [31:0] decPc, decInstr, decTarget;
  logic        resValid = 1'b0, resMispredict = 1'b0, resTaken = 1'b0;
  logic [31:0] resPc = '0, resTarget = '0;
  logic [15:0] totalCount, correctCount;

  always #2 clk = ~clk;

  btb_predictor i_btb_predictor (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .fetchInstr(fetchInstr),
    .nextPc(nextPc), .predTaken(predTaken),
    .decValid(decValid), .decPc(decPc), .decInstr(decInstr),
    .decTaken(decTaken), .decTarget(decTarget),
    .resValid(resValid), .resMispredict(resMispredict), .resPc(resPc),
    .resTaken(resTaken), .resTarget(resTarget),
    .totalCount(totalCount), .correctCount(correctCount)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model of the table
  bit          mV   [SETS][WAYS];
  bit          mTk  [SETS][WAYS];
  logic [31:0] mTag [SETS][WAYS];
  logic [31:0] mTgt [SETS][WAYS];
  longint      mStamp [SETS][WAYS];
  longint      mClock = 0;
  int          mTotal = 0, mCorrect = 0;

  // Expected decode bundle for the next check
  bit          eDecValid = 1'b0, eDecTaken = 1'b0;
  logic [31:0] eDecPc = '0, eDecInstr = '0, eDecTarget = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int setOf(input logic [31:0] pc);
    return int'(pc[5:2]);
  endfunction

  function automatic logic [31:0] tagOf(input logic [31:0] pc);
    return pc >> 6;
  endfunction

  function automatic int findWay(input logic [31:0] pc);
    int s = setOf(pc);
    for (int w = 0; w < WAYS; w++)
      if (mV[s][w] && mTag[s][w] == tagOf(pc)) return w;
    return -1;
  endfunction

  task automatic modelWrite(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
    int s = setOf(pc);
    int w = findWay(pc);
    if (w < 0) begin
      for (int k = WAYS - 1; k >= 0; k--) if (!mV[s][k]) w = k;
      if (w < 0) begin
        w = 0;
        for (int k = 1; k < WAYS; k++) if (mStamp[s][k] < mStamp[s][w]) w = k;
      end
    end
    mClock++;
    mV[s][w] = 1'b1; mTk[s][w] = tk; mTag[s][w] = tagOf(pc);
    mTgt[s][w] = tgt; mStamp[s][w] = mClock;
  endtask

  // One cycle: check registered results, drive, check combinational results
  task automatic step(input bit fv, input logic [31:0] fpc, input logic [31:0] finstr,
                      input bit rv, input bit rmis, input logic [31:0] rpc,
                      input bit rtk, input logic [31:0] rtgt);
    int w;
    bit eTk;
    logic [31:0] eNext;
    string req;
    @(negedge clk);
    chk(decValid == eDecValid, "R5", 32'(decValid), 32'(eDecValid));
    if (eDecValid) begin
      chk(decPc == eDecPc, "R5", decPc, eDecPc);
      chk(decInstr == eDecInstr, "R5", decInstr, eDecInstr);
      chk(decTaken == eDecTaken, "R5", 32'(decTaken), 32'(eDecTaken));
      chk(decTarget == eDecTarget, "R5", decTarget, eDecTarget);
    end
    chk(totalCount == 16'(mTotal), "R11", 32'(totalCount), 32'(16'(mTotal)));
    chk(correctCount == 16'(mCorrect), "R11", 32'(correctCount), 32'(16'(mCorrect)));
    fetchValid = fv; fetchPc = fpc; fetchInstr = finstr;
    resValid = rv; resMispredict = rmis; resPc = rpc; resTaken = rtk; resTarget = rtgt;
    #1;
    w = findWay(fpc);
    eTk = (w >= 0) && mTk[setOf(fpc)][w];
    eNext = eTk ? mTgt[setOf(fpc)][w] : fpc + 32'd4;
    req = (w < 0) ? "R2" : (eTk ? "R3" : "R4");
    chk(nextPc == eNext, req, nextPc, eNext);
    chk(predTaken == eTk, req, 32'(predTaken), 32'(eTk));
    eDecValid = fv; eDecPc = fpc; eDecInstr = finstr; eDecTaken = eTk; eDecTarget = eNext;
    if (rv) begin
      mTotal++;
      if (!rmis) mCorrect++;
      else modelWrite(rpc, rtk, rtgt);
    end
  endtask

  task automatic look(input logic [31:0] pc);
    step(1'b1, pc, pc ^ 32'hA5A5_0000, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] pA, pB, pC, pE, pA2;
    void'($urandom(32'd1234));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mV[s][w] = 1'b0; mStamp[s][w] = 0;
      end

    // R1: reset state
    fetchPc = 32'h0000_1004;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(decValid == 1'b0, "R1", 32'(decValid), 32'h0);
    chk(totalCount == 16'h0, "R1", 32'(totalCount), 32'h0);
    chk(correctCount == 16'h0, "R1", 32'(correctCount), 32'h0);
    chk(nextPc == 32'h0000_1008, "R1", nextPc, 32'h0000_1008);
    chk(predTaken == 1'b0, "R1", 32'(predTaken), 32'h0);
    rstN = 1'b1;

    pA  = 32'h0000_1004;   // set 1
    pB  = pA + 32'h40;     // set 1, other tag
    pC  = pA + 32'h80;     // set 1, third tag
    pA2 = pA + 32'h1000;   // set 1, tag differs only in high bits
    pE  = 32'h0000_1008;   // set 2

    // R10: lookup in the write cycle sees old contents
    step(1'b1, pA, 32'h1111, 1'b1, 1'b1, pA, 1'b1, 32'h0000_2000);
    chk(nextPc == pA + 32'd4, "R10", nextPc, pA + 32'd4);
    // R7/R3: written entry redirects
    look(pA);
    chk(nextPc == 32'h0000_2000, "R7", nextPc, 32'h0000_2000);
    // R6: same index, different tag is a separate miss
    look(pA2);
    chk(nextPc == pA2 + 32'd4, "R6", nextPc, pA2 + 32'd4);
    step(1'b0, 32'h0, 32'h0, 1'b1, 1'b1, pB, 1'b1, 32'h0000_3000);
    look(pB);
    chk(nextPc == 32'h0000_3000, "R6", nextPc, 32'h0000_3000);
    look(pA);
    chk(nextPc == 32'h0000_2000, "R6", nextPc, 32'h0000_2000);
    // R7: correct prediction leaves table alone
    step(1'b0, 32'h0, 32'h0, 1'b1, 1'b0, pA, 1'b0, 32'h0000_9000);
    look(pA);
    chk(nextPc == 32'h0000_2000, "R7", nextPc, 32'h0000_2000);
    // R9: in-place update refreshes recency of A
    step(1'b0, 32'h0, 32'h0, 1'b1, 1'b1, pA, 1'b1, 32'h0000_4000);
    look(pA);
    chk(nextPc == 32'h0000_4000, "R9", nextPc, 32'h0000_4000);
    // R8: full set evicts oldest write (B)
    step(1'b0, 32'h0, 32'h0, 1'b1, 1'b1, pC, 1'b1, 32'h0000_5000);
    look(pB);
    chk(predTaken == 1'b0, "R8", 32'(predTaken), 32'h0);
    look(pA);
    chk(nextPc == 32'h0000_4000, "R9", nextPc, 32'h0000_4000);
    look(pC);
    chk(nextPc == 32'h0000_5000, "R8", nextPc, 32'h0000_5000);
    // R4: not-taken hit falls through
    step(1'b0, 32'h0, 32'h0, 1'b1, 1'b1, pE, 1'b0, 32'h0000_6000);
    look(pE);
    chk(nextPc == pE + 32'd4, "R4", nextPc, pE + 32'd4);
    // R5: idle fetch
    step(1'b0, pA, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
    step(1'b0, pA, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);

    // Constrained random traffic over a small PC pool
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] fp, rp, tg;
      fp = 32'h0001_0000 | (($urandom % 5) << 6) | (($urandom % 4) << 2);
      rp = 32'h0001_0000 | (($urandom % 5) << 6) | (($urandom % 4) << 2);
      tg = $urandom & 32'hFFFF_FFFC;
      step(($urandom % 5) != 0, fp, $urandom, ($urandom % 2) == 0,
           ($urandom % 5) < 3, rp, ($urandom % 2) == 0, tg);
    end
    step(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule